// File: doc/BRIEF.md
# SPI Flash Chip-Erase Command Engine

This block is the device-side command logic of a small serial NOR flash. It oversamples a single-bit SPI link (chip-select, serial clock and data-in) with the system clock, shifts in opcode and argument bytes, and keeps an 8-bit status byte. That byte holds a busy flag, a write-enable latch and six protection bits. A host sets the latch, can change the protection bits, polls the status and reads the array. The main job is whole-array erase: when the host sends a valid erase command, a self-timed erase runs for a fixed number of clock cycles and then sets every array byte to 0xFF.

The erase is taken only under three conditions. The command must be exactly one byte long, so chip-select rises straight after the eighth bit. The write-enable latch must be set. The protection bits must leave the whole array open. While the erase runs, status polling still works and every other command is dropped. When the erase ends, the latch clears. The array is a small register file whose reset contents are a computed pattern, so the effect of an erase can be seen through ordinary reads.

Top module: `flash_erase_engine`

## Requirements
- R1: Opcodes 0xC7 and 0x60 both start a whole-array erase when chip-select rises after exactly 8 bits, the write-enable latch is 1 and nothing is protected. Data-in is sampled MSB first on rising SPI clock edges, and the erase starts from the chip-select rising edge.
- R2: An erase opcode sent while the write-enable latch is 0 has no effect. Status stays unchanged and array contents stay unchanged.
- R3: An erase opcode is not executed when chip-select rises after any bit count other than 8 (for example 7, 9 or 16 bits). The latch stays set and the busy flag stays 0.
- R4: The busy flag is 1 for exactly ERASE_CYCLES system clock cycles after an accepted erase, and then returns to 0.
- R5: While busy is 1, status reads (0x05) return live status with busy shown as 1. Write-enable, write-status, array-read and erase commands are ignored: status bits do not change and a read returns all-zero data.
- R6: The write-enable latch reads 0 once the erase has completed.
- R7: Status bits 7, 6 and 5 hold the complement, section and top/bottom selectors, and bits 4:2 hold a 3-bit region size. The array counts as partly protected when the complement bit is 0 and the size is not 0, or when the complement bit is 1 and the size is not 7. In that case an erase is rejected.
- R8: After a completed erase every array byte reads 0xFF. Read (0x03) is followed by an address byte and returns bytes MSB first from that address, incrementing and wrapping modulo MEM_BYTES.
- R9: After reset the status byte is 0x00 and array byte i holds i XOR INIT_XOR (default 0x5A).
- R10: Write-enable (0x06, 8 bits) sets status bit 1. Status read (0x05) shifts out the status byte MSB first, changing on falling SPI clock edges and repeating for as long as clocks continue, with busy in bit 0 and the latch in bit 1.
- R11: Write-status (0x01 followed by one data byte, exactly 16 bits) needs the latch set. It copies data bits 7:2 into status bits 7:2 and clears the latch. Without the latch it has no effect.
- R12: Data-out is 0 while chip-select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| spi_sck | input | 1 | SPI serial clock (mode 0) |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |

## Verification
A wrong bit counter or opcode latch shows up as an erase that starts when it should not, or one that is missed. The next status poll reveals either error within about sixteen SPI clocks, because busy or the latch reads back wrong. A wrong erase timer shows as busy dropping too early or too late. Only a status poll made close to the end of the erase window exposes this, so polls are placed on both sides of that edge. A wrong array update or latch clear stays hidden until the host reads data or status after completion, and the following read exposes it at once.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

   localparam logic [7:0] OP_WREN    = 8'h06;
   localparam logic [7:0] OP_RDSR    = 8'h05;
   localparam logic [7:0] OP_WRSR    = 8'h01;
   localparam logic [7:0] OP_READ    = 8'h03;
   localparam logic [7:0] OP_ERASE_A = 8'hC7;
   localparam logic [7:0] OP_ERASE_B = 8'h60;

   // protection field, occupies status bits 7:2
   typedef struct packed {
      logic       cmp;
      logic       sec;
      logic       tb;
      logic [2:0] bp;
   } guard_t;

   function automatic logic guard_blocks(guard_t g);
      return g.cmp ? (g.bp != 3'b111) : (g.bp != 3'b000);
   endfunction

   function automatic logic is_erase_op(logic [7:0] op);
      return (op == OP_ERASE_A) || (op == OP_ERASE_B);
   endfunction

endpackage

// File: rtl/spi_edge_front.sv
module spi_edge_front #(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n_i,
   input  logic             sck_i,
   input  logic             mosi_i,
   output logic             sel_o,
   output logic             cs_rise_o,
   output logic             sck_fall_o,
   output logic             byte_stb_o,
   output logic [CNT_W-1:0] bit_cnt_o,
   output logic [7:0]       rx_byte_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [SYNC_STAGES-1:0] cs_pipe, sck_pipe, mosi_pipe;

   generate
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  cs_pipe[0]   <= 1'b1;
                  sck_pipe[0]  <= 1'b0;
                  mosi_pipe[0] <= 1'b0;
               end else begin
                  cs_pipe[0]   <= cs_n_i;
                  sck_pipe[0]  <= sck_i;
                  mosi_pipe[0] <= mosi_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  cs_pipe[g]   <= 1'b1;
                  sck_pipe[g]  <= 1'b0;
                  mosi_pipe[g] <= 1'b0;
               end else begin
                  cs_pipe[g]   <= cs_pipe[g-1];
                  sck_pipe[g]  <= sck_pipe[g-1];
                  mosi_pipe[g] <= mosi_pipe[g-1];
               end
            end
         end
      end
   endgenerate

   logic cs_s, sck_s, mosi_s, cs_d, sck_d, sck_rise;
   logic [2:0] phase;
   logic [CNT_W-1:0] cnt;
   logic [7:0] shreg;
   logic stb;

   assign cs_s   = cs_pipe[SYNC_STAGES-1];
   assign sck_s  = sck_pipe[SYNC_STAGES-1];
   assign mosi_s = mosi_pipe[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d  <= 1'b1;
         sck_d <= 1'b0;
      end else begin
         cs_d  <= cs_s;
         sck_d <= sck_s;
      end
   end

   assign sel_o      = ~cs_s;
   assign sck_rise   = ~cs_s & sck_s & ~sck_d;
   assign sck_fall_o = ~cs_s & ~sck_s & sck_d;
   assign cs_rise_o  = cs_s & ~cs_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= '0;
         shreg <= '0;
         stb   <= 1'b0;
      end else begin
         stb <= sck_rise && (phase == 3'd7);
         if (cs_s) begin
            cnt   <= '0;
            phase <= '0;
         end else if (sck_rise) begin
            phase <= phase + 3'd1;
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
         end
         if (sck_rise) shreg <= {shreg[6:0], mosi_s};
      end
   end

   assign byte_stb_o = stb;
   assign bit_cnt_o  = cnt;
   assign rx_byte_o  = shreg;

endmodule

// File: rtl/erase_clock.sv
module erase_clock #(
   parameter int CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);

   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] left;
   logic          run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left <= '0;
         run  <= 1'b0;
      end else if (run) begin
         if (left == CW'(1)) begin
            run  <= 1'b0;
            left <= '0;
         end else begin
            left <= left - 1'b1;
         end
      end else if (start_i) begin
         run  <= 1'b1;
         left <= CW'(CYCLES);
      end
   end

   assign busy_o = run;
   assign done_o = run && (left == CW'(1));

endmodule

// File: rtl/flash_cells.sv
module flash_cells #(
   parameter int         BYTES    = 16,
   parameter int         ADDR_W   = 4,
   parameter logic [7:0] INIT_XOR = 8'h5A
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 erase_i,
   input  logic [ADDR_W-1:0]    raddr_i,
   output logic [7:0]           rdata_o,
   output logic [BYTES*8-1:0]   image_o
);

   logic [7:0] cells [BYTES];

   generate
      for (genvar g = 0; g < BYTES; g++) begin : g_cell
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cells[g] <= 8'(g) ^ INIT_XOR;
            else if (erase_i) cells[g] <= 8'hFF;
         end
         assign image_o[g*8 +: 8] = cells[g];
      end
   endgenerate

   assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/flash_erase_engine.sv
module flash_erase_engine
   import flash_erase_pkg::*;
#(
   parameter int         MEM_BYTES    = 16,
   parameter int         ERASE_CYCLES = 1000,
   parameter int         SYNC_STAGES  = 2,
   parameter int         CNT_W        = 12,
   parameter logic [7:0] INIT_XOR     = 8'h5A
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_cs_n,
   input  logic spi_sck,
   input  logic spi_mosi,
   output logic spi_miso
);

   localparam int ADDR_W = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;
   localparam logic [CNT_W-1:0] LEN_CMD  = CNT_W'(8);
   localparam logic [CNT_W-1:0] LEN_ARG  = CNT_W'(16);

   generate
      if (ERASE_CYCLES < 2) begin : g_bad_cycles
         $error("ERASE_CYCLES must be at least 2");
      end
      if (MEM_BYTES < 2 || MEM_BYTES > 256 || (MEM_BYTES & (MEM_BYTES - 1)) != 0) begin : g_bad_bytes
         $error("MEM_BYTES must be a power of two from 2 to 256");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CNT_W < 5) begin : g_bad_cnt
         $error("CNT_W must count at least 16 bits");
      end
   endgenerate

   logic             sel, cs_rise, sck_fall, byte_stb;
   logic [CNT_W-1:0] bit_cnt;
   logic [7:0]       rx_byte;
   logic             busy, erase_done, start_erase, set_wel, wr_status;
   logic             st_wel;
   guard_t           st_guard;
   logic [7:0]       op_q, tx_q, cell_rdata, status_byte;
   logic             miso_q, rd_act;
   logic [ADDR_W-1:0] addr_q, cell_raddr;
   logic [MEM_BYTES*8-1:0] cell_image;

   spi_edge_front #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_front (
      .clk(clk), .rst_n(rst_n),
      .cs_n_i(spi_cs_n), .sck_i(spi_sck), .mosi_i(spi_mosi),
      .sel_o(sel), .cs_rise_o(cs_rise), .sck_fall_o(sck_fall),
      .byte_stb_o(byte_stb), .bit_cnt_o(bit_cnt), .rx_byte_o(rx_byte)
   );

   erase_clock #(.CYCLES(ERASE_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start_i(start_erase),
      .busy_o(busy), .done_o(erase_done)
   );

   flash_cells #(.BYTES(MEM_BYTES), .ADDR_W(ADDR_W), .INIT_XOR(INIT_XOR)) u_cells (
      .clk(clk), .rst_n(rst_n), .erase_i(erase_done),
      .raddr_i(cell_raddr), .rdata_o(cell_rdata), .image_o(cell_image)
   );

   assign status_byte = {st_guard, st_wel, busy};
   assign cell_raddr  = (bit_cnt == LEN_ARG) ? rx_byte[ADDR_W-1:0] : addr_q;

   always_comb begin
      start_erase = cs_rise && (bit_cnt == LEN_CMD) && is_erase_op(op_q)
                    && !busy && st_wel && !guard_blocks(st_guard);
      set_wel     = cs_rise && (bit_cnt == LEN_CMD) && (op_q == OP_WREN) && !busy;
      wr_status   = cs_rise && (bit_cnt == LEN_ARG) && (op_q == OP_WRSR) && !busy && st_wel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_wel   <= 1'b0;
         st_guard <= '0;
      end else begin
         if (erase_done || wr_status) st_wel <= 1'b0;
         else if (set_wel)            st_wel <= 1'b1;
         if (wr_status) st_guard <= guard_t'(rx_byte[7:2]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= '0;
         tx_q   <= '0;
         miso_q <= 1'b0;
         rd_act <= 1'b0;
         addr_q <= '0;
      end else if (!sel) begin
         op_q   <= '0;
         tx_q   <= '0;
         miso_q <= 1'b0;
         rd_act <= 1'b0;
      end else if (byte_stb) begin
         if (bit_cnt == LEN_CMD) op_q <= rx_byte;
         if ((bit_cnt == LEN_CMD && rx_byte == OP_RDSR) ||
             (bit_cnt > LEN_CMD && op_q == OP_RDSR)) begin
            tx_q <= status_byte;
         end else if (bit_cnt == LEN_ARG && op_q == OP_READ && !busy) begin
            rd_act <= 1'b1;
            tx_q   <= cell_rdata;
            addr_q <= rx_byte[ADDR_W-1:0] + 1'b1;
         end else if (rd_act) begin
            tx_q   <= cell_rdata;
            addr_q <= addr_q + 1'b1;
         end
      end else if (sck_fall) begin
         miso_q <= tx_q[7];
         tx_q   <= {tx_q[6:0], 1'b0};
      end
   end

   assign spi_miso = miso_q;

endmodule

// File: rtl/flash_erase_chk.sv
module flash_erase_chk
   import flash_erase_pkg::*;
#(
   parameter int ERASE_CYCLES = 1000,
   parameter int MEM_BYTES    = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   busy,
   input logic                   wel,
   input logic [5:0]             guard,
   input logic [MEM_BYTES*8-1:0] image
);

   localparam int CW = $clog2(ERASE_CYCLES + 2);

   logic [CW-1:0] busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          busy_len <= '0;
      else if (!busy)                      busy_len <= '0;
      else if (busy_len != {CW{1'b1}})     busy_len <= busy_len + 1'b1;
   end

   AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> busy_len == CW'(ERASE_CYCLES)); // R4

   AST_WEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !wel); // R6

   AST_ARRAY_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (&image)); // R8

   AST_START_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wel)); // R2

   AST_START_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !guard_blocks(guard_t'($past(guard)))); // R7

   AST_GUARD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(guard)); // R5

   AST_WEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(wel)); // R5

endmodule

bind flash_erase_engine flash_erase_chk #(
   .ERASE_CYCLES(ERASE_CYCLES), .MEM_BYTES(MEM_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .wel(st_wel),
   .guard(st_guard), .image(cell_image)
);

// File: tb/tb_flash_erase_engine.sv
module tb_flash_erase_engine;

   localparam int E    = 1500;
   localparam int NB   = 16;
   localparam int HALF = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
   logic spi_miso;

   int unsigned tests = 0, fails = 0;
   longint unsigned cyc = 0;

   logic       m_wel;
   logic [5:0] m_guard;
   logic [7:0] m_mem [NB];

   flash_erase_engine #(.MEM_BYTES(NB), .ERASE_CYCLES(E)) dut (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n),
      .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic m_blocked(logic [5:0] g);
      return g[5] ? (g[2:0] != 3'b111) : (g[2:0] != 3'b000);
   endfunction

   function automatic logic [7:0] m_status(logic b);
      return {m_guard, m_wel, b};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      m_wel = 1'b0;
      m_guard = '0;
      for (int i = 0; i < NB; i++) m_mem[i] = 8'(i) ^ 8'h5A;
   endtask

   task automatic xfer(input logic [63:0] d, input int n, output logic [63:0] r);
      r = '0;
      @(negedge clk);
      spi_cs_n = 1'b0;
      repeat (2) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         spi_mosi = d[n-1-i];
         repeat (HALF) @(negedge clk);
         r = {r[62:0], spi_miso};
         spi_sck = 1'b1;
         repeat (HALF) @(negedge clk);
         spi_sck = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic rdsr(output logic [7:0] s);
      logic [63:0] r;
      xfer(64'h0500, 16, r);
      s = r[7:0];
   endtask

   task automatic wren();
      logic [63:0] r;
      xfer(64'h06, 8, r);
      m_wel = 1'b1;
   endtask

   task automatic wrsr(input logic [7:0] v);
      logic [63:0] r;
      xfer({48'h0, 8'h01, v}, 16, r);
      if (m_wel) begin
         m_guard = v[7:2];
         m_wel = 1'b0;
      end
   endtask

   task automatic read_chk(input int a, input int nb, input string tag, input bit zero_exp);
      logic [63:0] r;
      xfer({48'h0, 8'h03, 8'(a)} << (8 * nb), 16 + 8 * nb, r);
      for (int k = 0; k < nb; k++) begin
         logic [7:0] e;
         e = zero_exp ? 8'h00 : m_mem[(a + k) % NB];
         check(r[(nb-1-k)*8 +: 8] == e, tag, r[(nb-1-k)*8 +: 8], e);
      end
   endtask

   task automatic status_chk(input logic b, input string tag);
      logic [7:0] s;
      rdsr(s);
      check(s == m_status(b), tag, s, m_status(b));
   endtask

   task automatic erase_send(input logic [7:0] op, input int n, output bit acc);
      logic [63:0] d, r;
      if (n >= 8)
         d = ({56'h0, op} << (n - 8)) | ({$urandom, $urandom} & ((64'd1 << (n - 8)) - 1));
      else
         d = 64'(op >> (8 - n));
      acc = (n == 8) && (op == 8'hC7 || op == 8'h60) && m_wel && !m_blocked(m_guard);
      xfer(d, n, r);
   endtask

   task automatic finish_erase(input string tag);
      repeat (E) @(negedge clk);
      m_wel = 1'b0;
      for (int i = 0; i < NB; i++) m_mem[i] = 8'hFF;
      status_chk(1'b0, tag);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog R4 actual=timeout expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      bit acc;
      logic [7:0] s;
      longint unsigned t0;
      void'($urandom(32'd7741));

      do_reset();
      check(spi_miso == 1'b0, "R12 idle miso", spi_miso, 0);
      status_chk(1'b0, "R9 reset status");
      read_chk(14, 4, "R9 R8 reset pattern wrap", 1'b0);

      // R2: erase without the latch
      erase_send(8'hC7, 8, acc);
      status_chk(1'b0, "R2 no wel");
      read_chk(0, 2, "R2 array kept", 1'b0);

      // R10: write enable
      wren();
      status_chk(1'b0, "R10 wel set");

      // R3: wrong lengths
      erase_send(8'hC7, 7, acc);
      status_chk(1'b0, "R3 seven bits");
      erase_send(8'h60, 9, acc);
      status_chk(1'b0, "R3 nine bits");
      erase_send(8'hC7, 16, acc);
      status_chk(1'b0, "R3 sixteen bits");

      // R11 and R7: protection rejects erase
      wrsr(8'h04);
      status_chk(1'b0, "R11 guard write");
      wren();
      erase_send(8'h60, 8, acc);
      status_chk(1'b0, "R7 protected reject");
      wrsr(8'h9C);
      status_chk(1'b0, "R11 complement full");
      wrsr(8'h00);
      status_chk(1'b0, "R11 ignored without wel");

      // R1: 0x60 accepted, busy timing and blocking
      wren();
      erase_send(8'h60, 8, acc);
      t0 = cyc;
      status_chk(1'b1, "R1 R5 busy after 0x60");
      wrsr(8'h00);
      m_guard = 6'h27;
      m_wel = 1'b1;
      read_chk(3, 2, "R5 read blocked", 1'b1);
      xfer(64'h06, 8, s);
      wait (cyc >= t0 + E - 200);
      status_chk(1'b1, "R4 still busy");
      wait (cyc >= t0 + E + 10);
      m_wel = 1'b0;
      for (int i = 0; i < NB; i++) m_mem[i] = 8'hFF;
      status_chk(1'b0, "R4 R6 R5 done");
      read_chk(0, 6, "R8 erased low", 1'b0);
      read_chk(6, 6, "R8 erased mid", 1'b0);
      read_chk(12, 4, "R8 erased top", 1'b0);
      check(spi_miso == 1'b0, "R12 miso after read", spi_miso, 0);

      // R1: 0xC7 accepted
      do_reset();
      wren();
      erase_send(8'hC7, 8, acc);
      status_chk(1'b1, "R1 busy after 0xC7");
      finish_erase("R1 R6 C7 done");
      read_chk(9, 5, "R1 R8 C7 erased", 1'b0);

      // random mix
      do_reset();
      for (int it = 0; it < 90; it++) begin
         int sel;
         sel = int'($urandom % 12);
         if (sel < 2) begin
            wren();
         end else if (sel < 4) begin
            wrsr(($urandom % 2) ? 8'h00 : 8'($urandom));
         end else if (sel < 7) begin
            logic [7:0] op;
            int n;
            case ($urandom % 4)
               0: op = 8'hC7;
               1: op = 8'h60;
               2: op = 8'hC6;
               default: op = 8'hE7;
            endcase
            n = ($urandom % 10 < 7) ? 8 : int'(5 + $urandom % 10);
            erase_send(op, n, acc);
            if (acc) begin
               status_chk(1'b1, "R1 R4 random busy");
               finish_erase("R6 random done");
            end else begin
               status_chk(1'b0, "R2 R3 R7 random reject");
            end
         end else if (sel < 9) begin
            status_chk(1'b0, "R10 random status");
         end else if (sel < 11) begin
            read_chk(int'($urandom % NB), int'(1 + $urandom % 4), "R8 random read", 1'b0);
         end else begin
            do_reset();
            status_chk(1'b0, "R9 random reset");
         end
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule